// File: doc/BRIEF.md
# Configurable I/O Port with Latched Low Address Output

This block is a bidirectional port of `PORT_W` pins (8 by default) that sits beside a microcontroller with a multiplexed address/data bus. Each pin can be used in two ways. As a general I/O bit, its driver is enabled by a direction bit and it drives the value of a data bit. As an address pin, it drives one bit of the low address that an internal register captures from the multiplexed bus.

Software sets the port up through a small register bus with four word offsets. Offset 0 gives the live pin levels. Offset 1 holds the direction bits, offset 2 the data bits and offset 3 the mode bits. Writes are synchronous to `clk` and happen on `reg_we`. Reads are combinational from `reg_addr`.

The address capture register is clocked by the falling edge of `ale`. A parameter mask, `ADDR_PIN_MASK`, selects which pins are able to enter address mode. The pad itself sits outside the block, so the pin appears as separate `pin_in`, `pin_out` and `pin_oe` vectors.

Top module: `latched_addr_port`

## Requirements
- R1: After reset, the direction, data and mode registers read 0 and `pin_oe` is all zeros, so every pin is an input.
- R2: A write with `reg_we` high at offset 1 (direction), 2 (data) or 3 (mode) updates that register on the next rising edge of `clk`. A read at that offset returns the stored value, not the pin level.
- R3: A read at offset 0 returns `pin_in` for every pin, whatever its direction. A write to offset 0 changes no register.
- R4: A pin with mode bit 0 has `pin_oe` equal to its direction bit (0 = input, 1 = output). When the pin drives, `pin_out` equals its data bit.
- R5: On each falling edge of `ale`, the capture register takes the low `PORT_W` bits of `mux_bus`. While `ale` stays low, changes on `mux_bus` leave it unchanged.
- R6: A pin with mode bit 1 has `pin_oe` forced to 1, whatever its direction bit, and drives the captured address bit.
- R7: Address output is tied to position. Pin n can only carry captured bit n.
- R8: For a pin whose bit in `ADDR_PIN_MASK` is 0, the mode bit always reads 0. Writing 1 to it has no effect on that pin's `pin_out` or `pin_oe`.
- R9: Each pin is configured on its own, so any mix of input, output and address pins works at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 pins, 1 direction, 2 data, 3 mode |
| reg_wdata | input | PORT_W | Write data |
| reg_rdata | output | PORT_W | Combinational read data |
| ale | input | 1 | Address latch enable; captured on its falling edge |
| mux_bus | input | PORT_W | Low bits of the multiplexed address/data bus |
| pin_in | input | PORT_W | Level seen at each pad |
| pin_out | output | PORT_W | Value driven toward each pad |
| pin_oe | output | PORT_W | Per-pin driver enable |

## Verification
The bench builds the block with `PORT_W` = 8 and `ADDR_PIN_MASK` = 8'h7F. With that mask, pin 7 is I/O-only while pins 0 to 6 can carry address bits. A single write of all ones to the mode register therefore shows both the forced drivers of the capable pins and the ignored mode bit of pin 7. Captured values with distinct bit patterns (C3, 12, 5A) bring position errors and bit swaps within reach. A bus change made while `ale` is low shows that the capture register holds between strobes.

// File: rtl/lap_pkg.sv
package lap_pkg;
   typedef enum logic [1:0] {
      OFF_PIN  = 2'd0,
      OFF_DIR  = 2'd1,
      OFF_DATA = 2'd2,
      OFF_MODE = 2'd3
   } reg_off_e;
endpackage

// File: rtl/lap_addr_capture.sv
module lap_addr_capture #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] addr_q
);
   // Capture on the trailing edge of the strobe; holds while it is low.
   always_ff @(negedge ale or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= bus_in;
   end

   // R5: no falling edge can occur while ale is low at two clk samples.
   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && $past(!ale)) |-> $stable(addr_q));
endmodule

// File: rtl/lap_reg_bank.sv
module lap_reg_bank
   import lap_pkg::*;
#(
   parameter int           W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [1:0]   addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] data_q,
   output logic [W-1:0] mode_q
);
   logic wr_dir, wr_data, wr_mode;
   assign wr_dir  = we && (addr == OFF_DIR);
   assign wr_data = we && (addr == OFF_DATA);
   assign wr_mode = we && (addr == OFF_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_data) data_q <= wdata;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_mode
      if (MASK[i]) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mode_q[i] <= 1'b0;
            else if (wr_mode) mode_q[i] <= wdata[i];
         end
      end else begin : g_fixed
         assign mode_q[i] = 1'b0;
      end
   end

   assert_wr_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(wdata));
   assert_wr_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> data_q == $past(wdata));
   assert_mode_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & ~MASK) == '0);
endmodule

// File: rtl/lap_pin_cell.sv
module lap_pin_cell (
   input  logic mode,
   input  logic dir,
   input  logic data,
   input  logic addr_bit,
   output logic out,
   output logic oe
);
   always_comb begin
      out = mode ? addr_bit : data;
      oe  = mode | dir;
   end
endmodule

// File: rtl/latched_addr_port.sv
module latched_addr_port
   import lap_pkg::*;
#(
   parameter int                PORT_W        = 8,
   parameter logic [PORT_W-1:0] ADDR_PIN_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [PORT_W-1:0] reg_wdata,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic              ale,
   input  logic [PORT_W-1:0] mux_bus,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   if (PORT_W < 1 || PORT_W > 32) begin : g_bad_width
      $error("PORT_W must be in 1..32");
   end

   logic [PORT_W-1:0] dir_q, data_q, mode_q, addr_q;

   lap_addr_capture #(.W(PORT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .ale(ale), .bus_in(mux_bus), .addr_q(addr_q)
   );

   lap_reg_bank #(.W(PORT_W), .MASK(ADDR_PIN_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .dir_q(dir_q), .data_q(data_q), .mode_q(mode_q)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      lap_pin_cell u_cell (
         .mode(mode_q[i]), .dir(dir_q[i]), .data(data_q[i]),
         .addr_bit(addr_q[i]), .out(pin_out[i]), .oe(pin_oe[i])
      );
   end

   always_comb begin
      unique case (reg_offset_cast(reg_addr))
         OFF_PIN:  reg_rdata = pin_in;
         OFF_DIR:  reg_rdata = dir_q;
         OFF_DATA: reg_rdata = data_q;
         OFF_MODE: reg_rdata = mode_q;
         default:  reg_rdata = '0;
      endcase
   end

   function automatic reg_off_e reg_offset_cast(input logic [1:0] a);
      return reg_off_e'(a);
   endfunction

   assert_mode_forces_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & ~pin_oe) == '0);
   assert_addr_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & (pin_out ^ addr_q)) == '0);
   assert_input_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~(dir_q | mode_q)) == '0);
   assert_reset_idle_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/tb_latched_addr_port.sv
module tb_latched_addr_port;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         ale = 1'b0;
   logic [W-1:0] mux_bus = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   latched_addr_port #(.PORT_W(W), .ADDR_PIN_MASK(8'h7F)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale(ale),
      .mux_bus(mux_bus), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ale_pulse(input logic [W-1:0] v);
      @(negedge clk);
      mux_bus = v; ale = 1'b1;
      @(negedge clk);
      ale = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [W-1:0] d;
      rd(2'd1, d); chk("R1 dir", d, 8'h00);
      rd(2'd2, d); chk("R1 data", d, 8'h00);
      rd(2'd3, d); chk("R1 mode", d, 8'h00);
      chk("R1 oe", pin_oe, 8'h00);
   endtask

   task automatic t_regs;
      logic [W-1:0] d;
      pin_in = 8'hFF;
      wr(2'd1, 8'hA5);
      wr(2'd2, 8'h3C);
      rd(2'd1, d); chk("R2 dir", d, 8'hA5);
      rd(2'd2, d); chk("R2 data", d, 8'h3C);
   endtask

   task automatic t_io;
      chk("R4 oe", pin_oe, 8'hA5);
      chk("R4 out", pin_out & pin_oe, 8'h3C & 8'hA5);
   endtask

   task automatic t_pinread;
      logic [W-1:0] d;
      pin_in = 8'h5A;
      rd(2'd0, d); chk("R3 pins", d, 8'h5A);
      wr(2'd0, 8'hFF);
      rd(2'd1, d); chk("R3 dir unchanged", d, 8'hA5);
      rd(2'd2, d); chk("R3 data unchanged", d, 8'h3C);
      rd(2'd3, d); chk("R3 mode unchanged", d, 8'h00);
   endtask

   task automatic t_addr;
      logic [W-1:0] d;
      ale_pulse(8'hC3);
      wr(2'd3, 8'hFF);
      rd(2'd3, d); chk("R8 mode masked", d, 8'h7F);
      chk("R6 oe forced", pin_oe, 8'hFF);
      chk("R6 R7 addr bits", pin_out & 8'h7F, 8'hC3 & 8'h7F);
      chk("R8 pin7 data", pin_out & 8'h80, 8'h00);
      @(negedge clk); mux_bus = 8'h12;
      @(negedge clk); @(negedge clk); #1;
      chk("R5 hold", pin_out & 8'h7F, 8'h43);
      ale_pulse(8'h12);
      chk("R5 new capture", pin_out & 8'h7F, 8'h12);
   endtask

   task automatic t_mixed;
      wr(2'd3, 8'h0F);
      wr(2'd1, 8'hF0);
      wr(2'd2, 8'hA0);
      ale_pulse(8'h5A);
      chk("R9 oe", pin_oe, 8'hFF);
      chk("R9 R7 out", pin_out, 8'hAA);
      wr(2'd1, 8'h30);
      chk("R9 oe mixed", pin_oe, 8'h3F);
      chk("R9 out mixed", pin_out & pin_oe, 8'h2A);
      wr(2'd3, 8'h00);
      wr(2'd1, 8'h00);
      chk("R4 all input", pin_oe, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_io();
      t_pinread();
      t_addr();
      t_mixed();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule